// File: doc/BRIEF.md
# Bus-Invert Transmitter and Receiver

This block is a linked encoder and decoder for a wide data bus. Its purpose is to reduce how many bus lines change state on each transfer. The bus is split into equal lanes, and each lane has its own polarity wire.

When a word is accepted, the encoder compares each lane of the word with the value its bus register holds for that lane. It counts how many lines would toggle if it sent the word unchanged and how many would toggle if it sent the complement. The count includes the lane's polarity wire. The encoder registers the cheaper choice and sets the polarity bit to show which choice it made.

The receiving side XORs each lane with its polarity bit and registers the result. The source word therefore reappears one cycle after it was placed on the bus. No correlation between successive words is assumed, so counting sequences and random streams are handled the same way.

Top module: `businv_link`

## Requirements
- R1: While reset is asserted, `bus_data` is all zeros, `bus_pol` is all zeros (true polarity), `rx_data` is all zeros and `rx_valid` is low.
- R2: A word presented with `src_valid` high at a clock edge appears on `bus_data` after that edge. Lane g is bits [g*LANE_W +: LANE_W]. A lane carries the source bits unchanged when its `bus_pol` bit is 0 and their bitwise complement when that bit is 1.
- R3: For each lane, let h be the number of bits where the new word differs from the current `bus_data` lane, and let p be the current polarity bit. Sending true costs h+p toggles and sending inverted costs LANE_W-h+1-p toggles. The lane takes the cheaper option; on an equal cost it keeps p.
- R4: For an even LANE_W, no accepted word toggles more than LANE_W/2 lines of a lane, counting its data lines and its polarity line together.
- R5: While `src_valid` is low, `bus_data` and `bus_pol` keep their values, whatever is on `src_data`.
- R6: One cycle after a word reaches the bus, `rx_valid` is high for one cycle and `rx_data` equals that source word. Each word is restored exactly once and in order.
- R7: Each lane's polarity decision depends only on that lane's own bits; a lane whose data does not change keeps its polarity.
- R8: While `rx_valid` is low, `rx_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source word strobe |
| src_data | input | DATA_W | Source word |
| bus_data | output | DATA_W | Encoded bus lines |
| bus_pol | output | LANES | Per-lane polarity, 1 = complemented |
| rx_data | output | DATA_W | Restored word |
| rx_valid | output | 1 | Restored word strobe |

## Verification
Two things can happen in the same cycle. The encoder may flip a lane's polarity for a new word while the decoder is restoring the previous word with the old polarity. The bench drives words back to back with no gaps to make this happen. It uses explicit patterns that flip one lane and keep the other, and random bursts with idle gaps between them. A scoreboard queue compares every restored word with the source word in order. Each new bus value is checked against an encoding computed from the cost rule, and the toggle limit per lane is checked on every accepted word.

// File: rtl/businv_link.sv
module businv_link #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] bus_data,
  output logic [LANES-1:0]  bus_pol,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int CW     = $clog2(LANE_W + 2);

  logic [DATA_W-1:0] bus_q, rx_q, enc_word, pol_mask;
  logic [LANES-1:0]  pol_q, inv_sel;
  logic              vld_q, rxv_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] diff;
    logic [CW-1:0]     hd, c_true, c_inv;

    assign diff = src_data[g*LANE_W +: LANE_W] ^ bus_q[g*LANE_W +: LANE_W];

    always_comb begin
      hd = '0;
      for (int i = 0; i < LANE_W; i++) hd = hd + CW'(diff[i]);
    end

    assign c_true = hd + CW'(pol_q[g]);
    assign c_inv  = CW'(LANE_W) - hd + CW'(!pol_q[g]);
    assign inv_sel[g] = (c_inv < c_true) ? 1'b1 :
                        (c_inv > c_true) ? 1'b0 : pol_q[g];
    assign enc_word[g*LANE_W +: LANE_W] = inv_sel[g] ? ~src_data[g*LANE_W +: LANE_W]
                                                     :  src_data[g*LANE_W +: LANE_W];
    assign pol_mask[g*LANE_W +: LANE_W] = {LANE_W{pol_q[g]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      pol_q <= '0;
      vld_q <= 1'b0;
      rx_q  <= '0;
      rxv_q <= 1'b0;
    end else begin
      if (src_valid) begin
        bus_q <= enc_word;
        pol_q <= inv_sel;
      end
      vld_q <= src_valid;
      if (vld_q) rx_q <= bus_q ^ pol_mask;
      rxv_q <= vld_q;
    end
  end

  assign bus_data = bus_q;
  assign bus_pol  = pol_q;
  assign rx_data  = rx_q;
  assign rx_valid = rxv_q;
endmodule

module businv_link_chk #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_valid,
  input logic [DATA_W-1:0] src_data,
  input logic [DATA_W-1:0] bus_data,
  input logic [LANES-1:0]  bus_pol,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid
);
  localparam int LANE_W = DATA_W / LANES;

  logic [DATA_W-1:0] mask;
  for (genvar g = 0; g < LANES; g++) begin : g_m
    assign mask[g*LANE_W +: LANE_W] = {LANE_W{bus_pol[g]}};

    if (LANE_W % 2 == 0) begin : g_even
      a_r4_toggle_cap: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid |=> ($countones(bus_data[g*LANE_W +: LANE_W] ^ $past(bus_data[g*LANE_W +: LANE_W]))
                       + int'(bus_pol[g] != $past(bus_pol[g]))) <= LANE_W / 2);
    end
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> ($stable(bus_data) && $stable(bus_pol)));

  a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_data == $past(bus_data ^ mask));

  a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> ##1 rx_valid);

  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  always_comb if (!rst_n) a_r1_reset: assert (bus_data == '0 && bus_pol == '0 && !rx_valid);
endmodule

bind businv_link businv_link_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
  .bus_data(bus_data), .bus_pol(bus_pol), .rx_data(rx_data), .rx_valid(rx_valid));

// File: tb/businv_link_test.sv
`timescale 1ns/1ps
module businv_link_test;
  localparam int DW = 16, NL = 2, LW = DW / NL;

  logic clk = 0, rst_n = 0, src_valid = 0;
  logic [DW-1:0] src_data = '0;
  logic [DW-1:0] bus_data, rx_data;
  logic [NL-1:0] bus_pol;
  logic rx_valid;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] m_bus = '0, last_rx = '0;
  logic [NL-1:0] m_pol = '0;

  businv_link #(.DATA_W(DW), .LANES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .bus_data(bus_data), .bus_pol(bus_pol), .rx_data(rx_data), .rx_valid(rx_valid));

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [DW-1:0] d);
    logic [DW-1:0] nb;
    logic [NL-1:0] np;
    src_valid = 1; src_data = d;
    for (int g = 0; g < NL; g++) begin
      int h, ct, ci;
      h  = $countones(d[g*LW +: LW] ^ m_bus[g*LW +: LW]);
      ct = h + int'(m_pol[g]);
      ci = LW - h + 1 - int'(m_pol[g]);
      np[g] = (ci < ct) ? 1'b1 : (ci > ct) ? 1'b0 : m_pol[g];
      nb[g*LW +: LW] = np[g] ? ~d[g*LW +: LW] : d[g*LW +: LW];
    end
    @(negedge clk);
    check("R2 bus word", 32'(bus_data), 32'(nb));
    check("R3 polarity", 32'(bus_pol), 32'(np));
    for (int g = 0; g < NL; g++) begin
      int t;
      t = $countones(bus_data[g*LW +: LW] ^ m_bus[g*LW +: LW]) + int'(bus_pol[g] != m_pol[g]);
      check("R4 toggle cap", 32'(t <= LW / 2), 32'(1));
    end
    m_bus = nb; m_pol = np;
    exp_q.push_back(d);
  endtask

  task automatic idle(int n);
    src_valid = 0;
    for (int i = 0; i < n; i++) begin
      src_data = DW'($urandom);
      @(negedge clk);
      check("R5 hold bus", 32'(bus_data), 32'(m_bus));
      check("R5 hold pol", 32'(bus_pol), 32'(m_pol));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) check("R6 unexpected word", 32'(rx_data), 32'hDEAD);
        else check("R6 restored word", 32'(rx_data), 32'(exp_q.pop_front()));
        last_rx = rx_data;
      end else begin
        check("R8 rx hold", 32'(rx_data), 32'(last_rx));
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset bus", 32'(bus_data), 32'h0);
    check("R1 reset pol", 32'(bus_pol), 32'h0);
    check("R1 reset rx", 32'({rx_valid, rx_data}), 32'h0);
    rst_n = 1;
    @(negedge clk);

    send(16'h0000);
    send(16'hFFFF);
    check("R3 full flip inverts both lanes", 32'({bus_pol, bus_data}), 32'h30000);
    send(16'h00FF);
    check("R7 lane0 stays inverted, lane1 true", 32'({bus_pol, bus_data}), 32'h10000);
    send(16'h0F0F);
    check("R7 lanes decide apart", 32'({bus_pol, bus_data}), 32'h10FF0);
    send(16'h0F0F);
    check("R7 unchanged word keeps polarity", 32'(bus_pol), 32'h1);
    idle(3);

    for (int i = 0; i < 64; i++) send(DW'(i));
    idle(2);
    for (int b = 0; b < 20; b++) begin
      int len;
      len = 1 + ($urandom % 12);
      for (int i = 0; i < len; i++) send(DW'($urandom));
      idle(1 + ($urandom % 3));
    end
    for (int i = 0; i < 16; i++) send((i % 2) ? 16'hAAAA : 16'h5555);
    idle(4);
    check("R6 all words restored", 32'(exp_q.size()), 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule